// File: doc/BRIEF.md
# Volts-per-hertz command path

This block turns a normalized speed request into the two commands that steer a constant flux induction motor drive: a stator frequency command and a stator voltage command. Each sample strobe pushes one update through a short pipeline. The request is smoothed by a first-order lag whose speed is set by a shift count. The smoothed request is compared with the measured speed, and a PI regulator turns the difference into a torque demand. That demand is clamped to a window from zero to a settable limit, because the drive only motors. The clamped torque stands in for slip. It is added to the measured speed to give the frequency command.

The voltage command is a boost offset plus a gain times frequency, capped at rated voltage. Above base speed the voltage therefore stays flat while frequency keeps rising, which gives field weakening. All quantities are signed Q4.12: 4096 is one per unit. Gains, the boost and the limit are held on configuration inputs and read on each update. The integrator stops growing while the clamp is engaged and the error would push it further in.

Top module: `vhz_cmd_path`

## Requirements
- R1: While `rst` is high at a rising edge, the ramp state and the integrator clear to 0, and `freq_cmd`, `volt_cmd` and `cmd_valid` all go to 0.
- R2: On each rising edge with `smp_stb` high, the ramp state y becomes y + ((spd_ref − y) >>> lag_shift), using an arithmetic shift that floors. With lag_shift = 0, y equals spd_ref.
- R3: The error e is y − fb, where fb is `spd_fb` sampled with the strobe. The torque demand is u = ((kp_gain·e) >>> 12) + I. The gains are unsigned Q4.12, and I is the integrator value after this sample's update.
- R4: On each sample the integrator adds d = (ki_gain·e) >>> 12, unless the update is frozen by R6.
- R5: The torque command is u clamped to [0, L]. L is `torque_lim`, and a negative `torque_lim` acts as L = 0.
- R6: The integrator holds its value when d > 0 and P + I + d > L, or when d < 0 and P + I + d < 0, where P is the proportional term.
- R7: `freq_cmd` equals the clamped torque plus fb, limited to [FMIN, FMAX]. The defaults are 7 and 5871, which is 0.1 Hz and 86 Hz against a 60 Hz base.
- R8: `volt_cmd` equals boost_v + ((vhz_gain·freq_cmd) >> 12), saturated at VMAX. VMAX defaults to 4096, which is 1.0 per unit.
- R9: A strobe sampled at edge E0 makes `cmd_valid` high for one cycle after edge E0+2. `freq_cmd` and `volt_cmd` change only at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe that starts one update |
| spd_ref | input | 16 | Speed request, signed Q4.12 |
| spd_fb | input | 16 | Measured speed, signed Q4.12 |
| lag_shift | input | 4 | Ramp shift count |
| kp_gain | input | 16 | Proportional gain, unsigned Q4.12 |
| ki_gain | input | 16 | Per-sample integral gain, unsigned Q4.12 |
| torque_lim | input | 16 | Torque ceiling, signed Q4.12 |
| boost_v | input | 16 | Low-speed voltage boost, unsigned Q4.12 |
| vhz_gain | input | 16 | Voltage-per-frequency gain, unsigned Q4.12 |
| freq_cmd | output | 16 | Stator frequency command, signed Q4.12 |
| volt_cmd | output | 16 | Stator voltage command, unsigned Q4.12 |
| cmd_valid | output | 1 | One-cycle pulse when new commands appear |

## Verification
Some properties are checked on every cycle:
- the torque command stays inside the clamp window;
- the frequency stays inside its band;
- the voltage never exceeds its ceiling;
- the integrator stays still whenever the freeze condition holds;
- the outputs hold between valid pulses;
- each valid pulse follows a strobe by exactly three edges.

Other behaviour shows up only in the bench's scenarios, which compare outputs against a model over sequences of samples:
- the exact regulator arithmetic and the integrator history it carries;
- the ramp's progress under a nonzero shift;
- anti-windup recovery after a long stretch in the clamp.

// File: rtl/vhz_pkg.sv
package vhz_pkg;
  localparam int DATA_W  = 16;
  localparam int FRAC_W  = 12;
  localparam int SHIFT_W = 4;
  localparam int ACC_W   = 24;
  localparam int F_LO    = 7;
  localparam int F_HI    = 5871;
  localparam int V_TOP   = 1 << FRAC_W;
  typedef logic signed [DATA_W-1:0] q_t;
endpackage

// File: rtl/vhz_ramp.sv
module vhz_ramp #(
  parameter int W       = 16,
  parameter int SHIFT_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stb_i,
  input  logic signed [W-1:0] x_i,
  input  logic [SHIFT_W-1:0]  k_i,
  output logic signed [W-1:0] y_o,
  output logic                vld_o
);
  logic signed [W:0] diff;
  logic signed [W:0] step;
  logic signed [W:0] nxt;

  always_comb begin
    diff = (W+1)'(x_i) - (W+1)'(y_o);
    step = diff >>> k_i;
    nxt  = (W+1)'(y_o) + step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= stb_i;
      if (stb_i) y_o <= nxt[W-1:0];
    end
  end

  // with no shift the ramp follows its input in one sample
  p_ramp_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (stb_i && k_i == '0) |=> (y_o == $past(x_i)));
endmodule

// File: rtl/vhz_pi.sv
module vhz_pi #(
  parameter int W     = 16,
  parameter int FRAC  = 12,
  parameter int INT_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vld_i,
  input  logic signed [W-1:0] sp_i,
  input  logic signed [W-1:0] fb_i,
  input  logic [W-1:0]        kp_i,
  input  logic [W-1:0]        ki_i,
  input  logic signed [W-1:0] tlim_i,
  output logic signed [W-1:0] torque_o,
  output logic signed [W-1:0] fb_o,
  output logic                vld_o
);
  localparam int EW = W + 1;
  localparam int PW = EW + W + 1;
  localparam int SW = PW + 2;
  localparam logic signed [SW-1:0] ZS   = '0;
  localparam logic signed [SW-1:0] AMAX = {{(SW-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}};
  localparam logic signed [SW-1:0] AMIN = ~AMAX;

  logic signed [INT_W-1:0] acc;
  logic signed [EW-1:0]    err;
  logic signed [PW-1:0]    p_full;
  logic signed [PW-1:0]    i_full;
  logic signed [SW-1:0]    p_term, d_term, acc_x, lim_x, trial;
  logic signed [SW-1:0]    acc_sum, acc_sat, acc_nxt, u, tq;
  logic                    frz;

  always_comb begin
    err     = EW'(sp_i) - EW'(fb_i);
    p_full  = $signed({1'b0, kp_i}) * err;
    i_full  = $signed({1'b0, ki_i}) * err;
    p_term  = SW'(p_full >>> FRAC);
    d_term  = SW'(i_full >>> FRAC);
    acc_x   = SW'(acc);
    lim_x   = tlim_i[W-1] ? ZS : SW'(tlim_i);
    trial   = p_term + acc_x + d_term;
    frz     = ((d_term > ZS) && (trial > lim_x)) || ((d_term < ZS) && (trial < ZS));
    acc_sum = acc_x + d_term;
    if (acc_sum > AMAX)      acc_sat = AMAX;
    else if (acc_sum < AMIN) acc_sat = AMIN;
    else                     acc_sat = acc_sum;
    acc_nxt = frz ? acc_x : acc_sat;
    u       = p_term + acc_nxt;
    if (u < ZS)         tq = ZS;
    else if (u > lim_x) tq = lim_x;
    else                tq = u;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      torque_o <= '0;
      fb_o     <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        acc      <= acc_nxt[INT_W-1:0];
        torque_o <= tq[W-1:0];
        fb_o     <= fb_i;
      end
    end
  end

  // torque never leaves [0, limit] (R5)
  p_torque_window_r5: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (torque_o >= 0) && ($past(tlim_i) < 0 ? torque_o == 0 : torque_o <= $past(tlim_i)));

  // integrator stays put while winding into the clamp (R6)
  p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (vld_i && frz) |=> $stable(acc));
endmodule

// File: rtl/vhz_volts.sv
module vhz_volts #(
  parameter int W    = 16,
  parameter int FRAC = 12,
  parameter int FMIN = 7,
  parameter int FMAX = 5871,
  parameter int VMAX = 4096
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vld_i,
  input  logic signed [W-1:0] slip_i,
  input  logic signed [W-1:0] fb_i,
  input  logic [W-1:0]        vo_i,
  input  logic [W-1:0]        kv_i,
  output logic signed [W-1:0] freq_o,
  output logic [W-1:0]        volt_o,
  output logic                vld_o
);
  localparam int EW = W + 1;
  localparam int MW = 2 * W;
  localparam logic signed [EW-1:0] FLO  = EW'(FMIN);
  localparam logic signed [EW-1:0] FHI  = EW'(FMAX);
  localparam logic [MW-1:0]        VTOP = MW'(VMAX);

  logic signed [EW-1:0] fsum, fclip;
  logic [MW-1:0]        prod, vsum;
  logic [W-1:0]         vnext;

  always_comb begin
    fsum = EW'(slip_i) + EW'(fb_i);
    if (fsum < FLO)      fclip = FLO;
    else if (fsum > FHI) fclip = FHI;
    else                 fclip = fsum;
    prod  = kv_i * fclip[W-1:0];
    vsum  = MW'(vo_i) + (prod >> FRAC);
    vnext = (vsum > VTOP) ? VTOP[W-1:0] : vsum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_o <= '0;
      volt_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        freq_o <= fclip[W-1:0];
        volt_o <= vnext;
      end
    end
  end

  p_freq_band_r7: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> (freq_o >= FLO[W-1:0]) && (freq_o <= FHI[W-1:0]));

  p_volt_ceiling_r8: assert property (@(posedge clk) disable iff (rst)
    MW'(volt_o) <= VTOP);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !vld_o |-> ($stable(freq_o) && $stable(volt_o)));
endmodule

// File: rtl/vhz_cmd_path.sv
module vhz_cmd_path
  import vhz_pkg::*;
#(
  parameter int W       = DATA_W,
  parameter int FRAC    = FRAC_W,
  parameter int SH_W    = SHIFT_W,
  parameter int INT_W   = ACC_W,
  parameter int FMIN    = F_LO,
  parameter int FMAX    = F_HI,
  parameter int VMAX    = V_TOP
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_stb,
  input  logic signed [W-1:0] spd_ref,
  input  logic signed [W-1:0] spd_fb,
  input  logic [SH_W-1:0]     lag_shift,
  input  logic [W-1:0]        kp_gain,
  input  logic [W-1:0]        ki_gain,
  input  logic signed [W-1:0] torque_lim,
  input  logic [W-1:0]        boost_v,
  input  logic [W-1:0]        vhz_gain,
  output logic signed [W-1:0] freq_cmd,
  output logic [W-1:0]        volt_cmd,
  output logic                cmd_valid
);
  logic signed [W-1:0] ramp_y, fb_q, torque, fb_p;
  logic                ramp_vld, pi_vld;

  always_ff @(posedge clk) begin
    if (rst)          fb_q <= '0;
    else if (smp_stb) fb_q <= spd_fb;
  end

  vhz_ramp #(.W(W), .SHIFT_W(SH_W)) u_ramp (
    .clk(clk), .rst(rst), .stb_i(smp_stb), .x_i(spd_ref), .k_i(lag_shift),
    .y_o(ramp_y), .vld_o(ramp_vld));

  vhz_pi #(.W(W), .FRAC(FRAC), .INT_W(INT_W)) u_pi (
    .clk(clk), .rst(rst), .vld_i(ramp_vld), .sp_i(ramp_y), .fb_i(fb_q),
    .kp_i(kp_gain), .ki_i(ki_gain), .tlim_i(torque_lim),
    .torque_o(torque), .fb_o(fb_p), .vld_o(pi_vld));

  vhz_volts #(.W(W), .FRAC(FRAC), .FMIN(FMIN), .FMAX(FMAX), .VMAX(VMAX)) u_volts (
    .clk(clk), .rst(rst), .vld_i(pi_vld), .slip_i(torque), .fb_i(fb_p),
    .vo_i(boost_v), .kv_i(vhz_gain),
    .freq_o(freq_cmd), .volt_o(volt_cmd), .vld_o(cmd_valid));

  // every valid pulse traces back to a strobe three edges earlier (R9)
  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(smp_stb, 3));
endmodule

// File: tb/tb_vhz_cmd_path.sv
module tb_vhz_cmd_path;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic signed [15:0] spd_ref = '0, spd_fb = '0, torque_lim = '0;
  logic [3:0]  lag_shift = '0;
  logic [15:0] kp_gain = '0, ki_gain = '0, boost_v = '0, vhz_gain = '0;
  logic signed [15:0] freq_cmd;
  logic [15:0] volt_cmd;
  logic cmd_valid;

  int nchk = 0;
  int nerr = 0;
  longint m_y = 0;
  longint m_i = 0;
  longint e_freq, e_volt;

  localparam longint FLO = 7;
  localparam longint FHI = 5871;
  localparam longint VTOP = 4096;
  localparam longint AMAX = (longint'(1) <<< 23) - 1;

  // columns: ref, fb, kp, ki, limit, boost, vhz gain, shift
  localparam int NV = 8;
  localparam int VT [NV][8] = '{
    '{2048, 1843,  4096,  410, 9830, 205, 3891, 0},
    '{4096,    0,  8192, 1024, 6000, 300, 4096, 0},
    '{1000, 3000,  4096,  512, 9830, 205, 3891, 0},
    '{6000, 5800, 20000,  256, 9830, 410, 4096, 0},
    '{   0, -500,  4096,  128, 9830, 100, 3700, 0},
    '{3000, 2900,     0, 2048, 9830, 205, 4000, 0},
    '{3000, 2900, 24576,    0, 9830,   0, 4096, 0},
    '{ 100,   90,  4096, 4096, 9830, 410, 4096, 0}
  };

  vhz_cmd_path dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .spd_ref(spd_ref), .spd_fb(spd_fb),
    .lag_shift(lag_shift), .kp_gain(kp_gain), .ki_gain(ki_gain),
    .torque_lim(torque_lim), .boost_v(boost_v), .vhz_gain(vhz_gain),
    .freq_cmd(freq_cmd), .volt_cmd(volt_cmd), .cmd_valid(cmd_valid));

  always #5 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input longint r, f, kp, ki, tl, vo, kv, k);
    longint e, p, d, trial, lim, u, t, fr, v;
    m_y = m_y + ((r - m_y) >>> k);
    e = m_y - f;
    p = (kp * e) >>> 12;
    d = (ki * e) >>> 12;
    lim = (tl < 0) ? 0 : tl;
    trial = p + m_i + d;
    if (!((d > 0 && trial > lim) || (d < 0 && trial < 0))) begin
      m_i = m_i + d;
      if (m_i > AMAX) m_i = AMAX;
      if (m_i < -AMAX - 1) m_i = -AMAX - 1;
    end
    u = p + m_i;
    t = (u < 0) ? 0 : ((u > lim) ? lim : u);
    fr = t + f;
    if (fr < FLO) fr = FLO;
    if (fr > FHI) fr = FHI;
    v = vo + ((kv * fr) >>> 12);
    if (v > VTOP) v = VTOP;
    e_freq = fr;
    e_volt = v;
  endtask

  task automatic run(input longint r, f, kp, ki, tl, vo, kv, k,
                     input string tf, input string tv, input bit lat);
    longint pf, pv;
    @(negedge clk);
    spd_ref = 16'(r); spd_fb = 16'(f); kp_gain = 16'(kp); ki_gain = 16'(ki);
    torque_lim = 16'(tl); boost_v = 16'(vo); vhz_gain = 16'(kv); lag_shift = 4'(k);
    pf = longint'(freq_cmd); pv = longint'(volt_cmd);
    smp_stb = 1'b1;
    model(r, f, kp, ki, tl, vo, kv, k);
    @(negedge clk);
    smp_stb = 1'b0;
    if (lat) check("R9 valid low one edge after strobe", longint'(cmd_valid), 0);
    @(negedge clk);
    if (lat) begin
      check("R9 valid low two edges after strobe", longint'(cmd_valid), 0);
      check("R9 freq held before update", longint'(freq_cmd), pf);
      check("R9 volt held before update", longint'(volt_cmd), pv);
    end
    @(negedge clk);
    check("R9 valid after third edge", longint'(cmd_valid), 1);
    check(tf, longint'(freq_cmd), e_freq);
    check(tv, longint'(volt_cmd), e_volt);
    if (lat) begin
      @(negedge clk);
      check("R9 valid is a single pulse", longint'(cmd_valid), 0);
      check("R9 freq held after pulse", longint'(freq_cmd), e_freq);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 freq_cmd cleared", longint'(freq_cmd), 0);
    check("R1 volt_cmd cleared", longint'(volt_cmd), 0);
    check("R1 cmd_valid cleared", longint'(cmd_valid), 0);
    rst = 1'b0;
    m_y = 0;
    m_i = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    do_reset();

    // table walk: the model carries ramp and integrator history across rows
    for (int i = 0; i < NV; i++) begin
      run(VT[i][0], VT[i][1], VT[i][2], VT[i][3], VT[i][4], VT[i][5], VT[i][6], VT[i][7],
          "R3 R4 R7 table freq", "R8 table volt", 1'b0);
    end

    // latency and hold on a fresh pipeline
    do_reset();
    run(1500, 1200, 4096, 200, 9830, 205, 4096, 0, "R7 freq", "R8 volt", 1'b1);

    // ramp with a shift of two, observed through a pure proportional path
    do_reset();
    run(4096, 0, 4096, 0, 20000, 0, 4096, 2, "R2 ramp first step", "R8 volt", 1'b0);
    run(4096, 0, 4096, 0, 20000, 0, 4096, 2, "R2 ramp second step", "R8 volt", 1'b0);
    run(4096, 0, 4096, 0, 20000, 0, 4096, 5, "R2 ramp shift five", "R8 volt", 1'b0);

    // negative limit behaves as zero torque
    do_reset();
    run(3000, 300, 4096, 100, -100, 0, 4096, 0, "R5 negative limit", "R8 volt", 1'b0);
    // torque pinned at the limit
    run(4000, 0, 16384, 0, 1000, 0, 4096, 0, "R5 torque at limit", "R8 volt", 1'b0);

    // anti-windup: long stay in the clamp, then a release
    do_reset();
    for (int j = 0; j < 5; j++)
      run(2000, 0, 4096, 4096, 1000, 0, 4096, 0, "R6 clamped", "R8 volt", 1'b0);
    run(500, 0, 4096, 4096, 1000, 0, 4096, 0, "R6 release step", "R8 volt", 1'b0);
    run(0, 0, 4096, 4096, 1000, 0, 4096, 0, "R6 integrator kept small", "R8 volt", 1'b0);

    // frequency floor and voltage at the low end
    do_reset();
    run(0, 0, 4096, 0, 9830, 300, 4096, 0, "R7 frequency floor", "R8 boost at floor", 1'b0);
    // frequency ceiling and voltage cap
    run(8000, 7000, 8192, 0, 9830, 410, 4096, 0, "R7 frequency ceiling", "R8 voltage cap", 1'b0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule